// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the fetch address for a program store of 2048 words, organised as two blocks of sixteen pages, each page holding sixty-four words. The address is built from three registers: a word counter, a page register and a block register. The word counter does not count in binary. It steps through a fixed maximal-length shift-register sequence that starts from zero. Page and block change only through a jump.

A jump that leaves the current page or block takes two instructions. The first instruction stages the target page in a page buffer, or stages the target block in a block buffer. The second is a branch or a call, and only when the status flag is 1 does it copy the buffers into the page and block registers. A branch or call with the status flag at 0 does not jump: it just steps the word counter and asks the status flag to be forced back to 1. A three-level return stack keeps the return word address together with its page and block, so a return restores the full location.

The sequencer is driven by decoded strobes from an external instruction decoder, one instruction per strobe cycle. A cycle with no strobe is a stall in which nothing changes.

Top module: `prog_addr_seq`

## Requirements
- R1: `fetch_addr_o` is formed as follows: bit 10 is the block register, bits 9..6 are the page register, and bits 5..0 are the word counter.
- R2: The word counter steps by the rule `next = {w[4:0], ~(w[5] ^ w[4])}`, which gives 0, 1, 3, 7, 0x0F, 0x1F, 0x3E and so on. The one value this rule never produces, 0x3F, steps to 0 so that the counter cannot lock up. Every instruction that is not a taken jump or a return uses this step.
- R3: `ld_pbuf_i` copies `page_op_i` into the page buffer. `set_bbuf_i` sets the block buffer to 1 and `clr_bbuf_i` clears it to 0. Each of these loads also steps the word counter. A loaded buffer keeps its value until it is used or loaded again.
- R4: A branch with `st_i`=1 copies the page buffer into the page register and the block buffer into the block register, and loads `word_op_i` into the word counter.
- R5: A branch or call with `st_i`=0 only steps the word counter. In that same cycle it raises `st_force_o`. Page, block and stack keep their values.
- R6: A call with `st_i`=1 jumps in the same way as a taken branch. It also pushes {current block, current page, stepped word address} into stack level 1, while level 1 moves to level 2 and level 2 moves to level 3. Whatever was in level 3 is lost.
- R7: A return does the following. It loads the word counter, the page register and the block register from stack level 1. It also loads the page buffer and the block buffer with the restored page and block. Level 2 moves to level 1 and level 3 moves to level 2, while level 3 keeps its own value. In that same cycle `st_force_o` is raised.
- R8: Reset (`rst_n`=0, asynchronous) clears the word counter, page register, block register, both buffers and the whole stack, so the fetch address is 0.
- R9: When the page buffer holds the current page and the block buffer holds the current block, a taken branch or call changes only the word address.
- R10: Plain advances and buffer loads leave page and block unchanged. A cycle with no strobe leaves the fetch address unchanged.
- R11: When several strobes are high together, only one acts, chosen in this priority order: return, call, branch, page buffer load, block buffer set, block buffer clear, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Plain instruction: step the word counter |
| br_i | input | 1 | Conditional branch |
| cal_i | input | 1 | Conditional call |
| rtn_i | input | 1 | Return from subroutine |
| ld_pbuf_i | input | 1 | Load the page buffer from `page_op_i` |
| set_bbuf_i | input | 1 | Set the block buffer to 1 |
| clr_bbuf_i | input | 1 | Clear the block buffer to 0 |
| word_op_i | input | 6 | Word address operand of a branch or call |
| page_op_i | input | 4 | Page operand of a page buffer load |
| st_i | input | 1 | Current status flag |
| fetch_addr_o | output | 11 | Fetch address {block, page, word} |
| st_force_o | output | 1 | Request to force the status flag to 1 |

## Verification
The hardest situation to reach from the ports is a stack that has overflowed and is then emptied. The stimulus stages buffers for three different pages and blocks and makes four nested taken calls, which pushes the oldest return location off the bottom. It then issues four returns: the last two must both land on the same location, because level 3 keeps its value when the levels shift up. The bench also loads word operand 0x3F through a taken branch and then advances, to show that the counter leaves the value its own sequence never produces.

// File: rtl/pas_pkg.sv
package pas_pkg;
    parameter int WORD_W      = 6;
    parameter int PAGE_W      = 4;
    parameter int BLK_W       = 1;
    parameter int STACK_DEPTH = 3;
    parameter int LFSR_TAP    = 5;   // second feedback tap, counted from 1

    localparam int ADDR_W = WORD_W + PAGE_W + BLK_W;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [PAGE_W-1:0] page;
        logic [WORD_W-1:0] word;
    } loc_t;

    typedef struct packed {
        loc_t              cur;
        logic [PAGE_W-1:0] pbuf;
        logic [BLK_W-1:0]  bbuf;
    } seq_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ADV,
        OP_LDPB,
        OP_SETBB,
        OP_CLRBB,
        OP_BR,
        OP_CAL,
        OP_RTN
    } op_e;
endpackage

// File: rtl/pas_decode.sv
module pas_decode
    import pas_pkg::*;
(
    input  logic adv_i,
    input  logic br_i,
    input  logic cal_i,
    input  logic rtn_i,
    input  logic ld_pbuf_i,
    input  logic set_bbuf_i,
    input  logic clr_bbuf_i,
    output op_e  op_o
);
    // Fixed priority: return, call, branch, buffer loads, advance (R11)
    always_comb begin
        if (rtn_i)           op_o = OP_RTN;
        else if (cal_i)      op_o = OP_CAL;
        else if (br_i)       op_o = OP_BR;
        else if (ld_pbuf_i)  op_o = OP_LDPB;
        else if (set_bbuf_i) op_o = OP_SETBB;
        else if (clr_bbuf_i) op_o = OP_CLRBB;
        else if (adv_i)      op_o = OP_ADV;
        else                 op_o = OP_IDLE;
    end
endmodule

// File: rtl/pas_lfsr_step.sv
module pas_lfsr_step #(
    parameter int WIDTH = 6,
    parameter int TAP   = 5
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic fb;

    // XNOR feedback keeps zero inside the cycle; all-ones is the lock-up value
    always_comb begin
        fb = ~(cur_i[WIDTH-1] ^ cur_i[TAP-1]);
        if (cur_i == {WIDTH{1'b1}})
            nxt_o = '0;
        else
            nxt_o = {cur_i[WIDTH-2:0], fb};
    end
endmodule

// File: rtl/pas_ret_stack.sv
module pas_ret_stack
    import pas_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    input  loc_t din_i,
    output loc_t top_o
);
    loc_t lvl_q [DEPTH];
    loc_t lvl_d [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
            always_comb begin
                lvl_d[i] = lvl_q[i];
                if (push_i) begin
                    if (i == 0) lvl_d[i] = din_i;
                    else        lvl_d[i] = lvl_q[(i == 0) ? 0 : i-1];
                end else if (pop_i) begin
                    if (i < DEPTH-1) lvl_d[i] = lvl_q[(i < DEPTH-1) ? i+1 : i];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lvl_q[i] <= '0;
                else        lvl_q[i] <= lvl_d[i];
            end
        end
    endgenerate

    assign top_o = lvl_q[0];

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(din_i)); // R6
    AST_POP_KEEP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-1])); // R7
    AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> top_o == $past(lvl_q[1])); // R7
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
    import pas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              br_i,
    input  logic              cal_i,
    input  logic              rtn_i,
    input  logic              ld_pbuf_i,
    input  logic              set_bbuf_i,
    input  logic              clr_bbuf_i,
    input  logic [WORD_W-1:0] word_op_i,
    input  logic [PAGE_W-1:0] page_op_i,
    input  logic              st_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              st_force_o
);
    op_e               op;
    seq_t              seq_d, seq_q;
    logic [WORD_W-1:0] word_step;
    loc_t              stk_top;
    loc_t              push_loc;
    logic              push, pop;

    pas_decode u_dec (
        .adv_i      (adv_i),
        .br_i       (br_i),
        .cal_i      (cal_i),
        .rtn_i      (rtn_i),
        .ld_pbuf_i  (ld_pbuf_i),
        .set_bbuf_i (set_bbuf_i),
        .clr_bbuf_i (clr_bbuf_i),
        .op_o       (op)
    );

    // One step unit serves both the sequential advance and the return address
    pas_lfsr_step #(.WIDTH(WORD_W), .TAP(LFSR_TAP)) u_step (
        .cur_i (seq_q.cur.word),
        .nxt_o (word_step)
    );

    pas_ret_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .pop_i  (pop),
        .din_i  (push_loc),
        .top_o  (stk_top)
    );

    always_comb begin
        seq_d      = seq_q;
        push       = 1'b0;
        pop        = 1'b0;
        st_force_o = 1'b0;
        push_loc   = '{blk: seq_q.cur.blk, page: seq_q.cur.page, word: word_step};
        unique case (op)
            OP_IDLE: ;
            OP_ADV:   seq_d.cur.word = word_step;
            OP_LDPB: begin
                seq_d.pbuf     = page_op_i;
                seq_d.cur.word = word_step;
            end
            OP_SETBB: begin
                seq_d.bbuf     = BLK_W'(1);
                seq_d.cur.word = word_step;
            end
            OP_CLRBB: begin
                seq_d.bbuf     = '0;
                seq_d.cur.word = word_step;
            end
            OP_BR, OP_CAL: begin
                if (st_i) begin
                    seq_d.cur.word = word_op_i;
                    seq_d.cur.page = seq_q.pbuf;
                    seq_d.cur.blk  = seq_q.bbuf;
                    push           = (op == OP_CAL);
                end else begin
                    seq_d.cur.word = word_step;
                    st_force_o     = 1'b1;
                end
            end
            OP_RTN: begin
                seq_d.cur  = stk_top;
                seq_d.pbuf = stk_top.page;
                seq_d.bbuf = stk_top.blk;
                pop        = 1'b1;
                st_force_o = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign fetch_addr_o = seq_q.cur;

    AST_PLAIN_HOLDS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_ADV, OP_LDPB, OP_SETBB, OP_CLRBB}) |=>
            fetch_addr_o[ADDR_W-1:WORD_W] == $past(fetch_addr_o[ADDR_W-1:WORD_W])); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> fetch_addr_o == $past(fetch_addr_o)); // R10
    AST_PBUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LDPB) |=> seq_q.pbuf == $past(page_op_i)); // R3
    AST_TAKEN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_BR || op == OP_CAL) && st_i) |=>
            (seq_q.cur.word == $past(word_op_i) && seq_q.cur.page == $past(seq_q.pbuf)
             && seq_q.cur.blk == $past(seq_q.bbuf))); // R4
    AST_NOT_TAKEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_BR || op == OP_CAL) && !st_i) |=>
            fetch_addr_o[ADDR_W-1:WORD_W] == $past(fetch_addr_o[ADDR_W-1:WORD_W])); // R5
    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADV && fetch_addr_o[WORD_W-1:0] == {WORD_W{1'b1}}) |=>
            fetch_addr_o[WORD_W-1:0] == '0); // R2
    AST_RTN_BUFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RTN) |=> (seq_q.pbuf == seq_q.cur.page && seq_q.bbuf == seq_q.cur.blk)); // R7
endmodule

// File: tb/sim_prog_addr_seq.sv
`timescale 1ns/1ps
module sim_prog_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_i = 0, br_i = 0, cal_i = 0, rtn_i = 0;
    logic        ld_pbuf_i = 0, set_bbuf_i = 0, clr_bbuf_i = 0;
    logic [5:0]  word_op_i = 0;
    logic [3:0]  page_op_i = 0;
    logic        st_i = 0;
    logic [10:0] fetch_addr_o;
    logic        st_force_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    // reference state
    logic [5:0]  mw;
    logic [3:0]  mp, mpb;
    logic        mb, mbb;
    logic [10:0] s0, s1, s2;

    always #4 clk = ~clk;   // 125 MHz

    prog_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .br_i(br_i), .cal_i(cal_i),
        .rtn_i(rtn_i), .ld_pbuf_i(ld_pbuf_i), .set_bbuf_i(set_bbuf_i),
        .clr_bbuf_i(clr_bbuf_i), .word_op_i(word_op_i), .page_op_i(page_op_i),
        .st_i(st_i), .fetch_addr_o(fetch_addr_o), .st_force_o(st_force_o)
    );

    function automatic logic [5:0] step(input logic [5:0] w);
        if (w == 6'h3f) return 6'h00;
        return {w[4:0], ~(w[5] ^ w[4])};
    endfunction

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mw = 0; mp = 0; mb = 0; mpb = 0; mbb = 0; s0 = 0; s1 = 0; s2 = 0;
    endtask

    // mask: [0]adv [1]ldpb [2]setbb [3]clrbb [4]br [5]cal [6]rtn
    task automatic issue(input logic [6:0] m, input logic [5:0] w, input logic [3:0] p,
                         input logic s, input string tag);
        logic force_e;
        force_e = 0;
        if (m[6]) begin
            {mb, mp, mw} = s0; mpb = mp; mbb = mb;
            s0 = s1; s1 = s2; force_e = 1;
        end else if (m[5] || m[4]) begin
            if (s) begin
                if (m[5]) begin
                    s2 = s1; s1 = s0; s0 = {mb, mp, step(mw)};
                end
                mw = w; mp = mpb; mb = mbb;
            end else begin
                mw = step(mw); force_e = 1;
            end
        end else if (m[1]) begin
            mpb = p; mw = step(mw);
        end else if (m[2]) begin
            mbb = 1; mw = step(mw);
        end else if (m[3]) begin
            mbb = 0; mw = step(mw);
        end else if (m[0]) begin
            mw = step(mw);
        end
        @(negedge clk);
        {rtn_i, cal_i, br_i, clr_bbuf_i, set_bbuf_i, ld_pbuf_i, adv_i} = m;
        word_op_i = w; page_op_i = p; st_i = s;
        #1;
        check({tag, " status request"}, {10'd0, st_force_o}, {10'd0, force_e});
        exp_q.push_back({mb, mp, mw});
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        {rtn_i, cal_i, br_i, clr_bbuf_i, set_bbuf_i, ld_pbuf_i, adv_i} = '0;
    endtask

    // monitor: compares the registered address after each instruction edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, fetch_addr_o, e);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 check("R8 reset address", fetch_addr_o, 11'h000);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < 8; i++) issue(7'h01, 0, 0, 0, "R2 advance");      // R2
        issue(7'h02, 0, 4'h5, 0, "R3 page buffer load");                     // R3 R10
        issue(7'h04, 0, 0, 0, "R3 block buffer set");                        // R3 R10
        issue(7'h01, 0, 0, 0, "R10 advance keeps page");                     // R10
        issue(7'h10, 6'h2a, 0, 0, "R5 branch not taken");                    // R5
        issue(7'h10, 6'h3f, 0, 1, "R4 long branch");                         // R4 R1
        issue(7'h01, 0, 0, 0, "R2 all-ones escape");                         // R2
        issue(7'h01, 0, 0, 0, "R2 advance from zero");                       // R2
        issue(7'h20, 6'h10, 0, 1, "R9 call within page");                    // R9 R6
        issue(7'h02, 0, 4'h2, 0, "R3 page buffer load");                     // R3
        issue(7'h08, 0, 0, 0, "R3 block buffer clear");                      // R3
        issue(7'h20, 6'h20, 0, 1, "R6 long call");                           // R6
        issue(7'h02, 0, 4'h9, 0, "R3 page buffer load");                     // R3
        issue(7'h04, 0, 0, 0, "R3 block buffer set");                        // R3
        issue(7'h20, 6'h05, 0, 1, "R6 third call");                          // R6
        issue(7'h20, 6'h06, 0, 1, "R6 overflowing call");                    // R6
        issue(7'h20, 6'h11, 0, 0, "R5 call not taken");                      // R5
        for (int i = 0; i < 4; i++) issue(7'h40, 0, 0, 0, "R7 return");       // R7
        issue(7'h01, 0, 0, 0, "R7 buffers restored then advance");           // R7
        issue(7'h10, 6'h01, 0, 1, "R7 branch uses restored buffers");        // R7 R9
        issue(7'h00, 0, 0, 0, "R10 idle holds");                             // R10
        issue(7'h00, 0, 0, 0, "R10 idle holds");                             // R10
        issue(7'h7f, 6'h22, 4'h3, 1, "R11 return wins");                     // R11
        issue(7'h3f, 6'h22, 4'h3, 1, "R11 call wins");                       // R11
        issue(7'h0f, 6'h00, 4'h7, 1, "R11 page load wins");                  // R11
        issue(7'h0d, 0, 0, 0, "R11 block set wins");                         // R11

        @(negedge clk) rst_n = 1'b0;
        model_reset();
        #1 check("R8 reset mid-run", fetch_addr_o, 11'h000);
        @(negedge clk) rst_n = 1'b1;
        issue(7'h01, 0, 0, 0, "R8 first step after reset");                  // R8 R2

        repeat (3) @(posedge clk);
        #3;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule